// File: doc/BRIEF.md
# Interleaved Multi-Bank Memory Controller

This block is the memory front end for strided vector streams. One start command gives a base word address, a two's-complement stride, an element count and a direction. The controller then walks the addresses `base + i*stride` (modulo the address space) and issues at most one element per clock. The word address is split across sixteen banks that work independently. Each bank stays occupied for a fixed number of cycles after an access.

A per-bank countdown timer marks each bank free or busy. While the bank of the next element is busy, the request is held without change, so only strides that come back to a bank within its busy window lose throughput. Read data comes back in element order after a fixed latency. A one-cycle done pulse closes every transfer. The banks are modelled as plain storage that resets to zero.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: Element i of a transfer addresses word `(base + i*stride) mod 256`. Bits [3:0] of that word address select the bank and bits [7:4] select the row inside the bank.
- R2: A bank that takes an access in cycle t takes no other access before cycle t+4.
- R3: `req_valid_o` is high while elements of the transfer remain to be issued. An element issues in a cycle where `req_valid_o` and `req_ready_o` are both high. `req_ready_o` is high exactly when the bank of `req_addr_o` is free.
- R4: While `req_valid_o` is high and `req_ready_o` is low, `req_addr_o` and `req_idx_o` hold their values into the next cycle.
- R5: Odd strides and the strides 2 and 4 never stall, so n elements issue in n consecutive cycles.
- R6: Strides that are multiples of 8 stall. Stride 8 issues two elements in every four cycles and stride 16 issues one element in every four cycles.
- R7: Negative strides are legal. The address wraps modulo 256.
- R8: A read element issued in cycle t appears in cycle t+4 on `rd_data_o` with `rd_valid_o` high and `rd_idx_o` equal to its element index. Elements return in element order.
- R9: `we_i`=1 selects a write transfer. `wdata_i` is captured in the issue cycle of each element, and a later read of that address returns it. Write transfers never raise `rd_valid_o`.
- R10: `done_o` is a one-cycle pulse in cycle t+5, where t is the issue cycle of the last element. A start with count 0 raises `done_o` in the cycle after it is accepted.
- R11: A `start_i` is accepted only when no transfer is in progress. A transfer is in progress from the cycle after acceptance through the cycle before its `done_o` pulse. A start at any other time is ignored.
- R12: After reset every output is low and every stored word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a transfer |
| we_i | input | 1 | 1 = write transfer, 0 = read transfer |
| base_addr_i | input | 8 | Word address of element 0 |
| stride_i | input | 8 | Signed address step between elements |
| count_i | input | 7 | Number of elements (0 to 64) |
| wdata_i | input | 16 | Write data for the element issuing this cycle |
| req_valid_o | output | 1 | An element is waiting to issue |
| req_ready_o | output | 1 | Bank of the waiting element is free |
| req_addr_o | output | 8 | Word address of the waiting element |
| req_idx_o | output | 7 | Index of the waiting element |
| rd_valid_o | output | 1 | Read data valid |
| rd_idx_o | output | 7 | Element index of the returned data |
| rd_data_o | output | 16 | Returned read data |
| done_o | output | 1 | Transfer finished (one-cycle pulse) |

## Verification
Strides 1, 2, 3 and 4 show that bank rotation alone sustains one element per cycle. Strides 8 and 16, and their negatives, show that the busy timers cost exactly the lost cycles of a revisited bank and no others. Write sweeps followed by reads at other strides and base offsets confirm that bank and row decoding, wrap-around and the ordered return line up with the element index. A start pulsed in the middle of a transfer, and a zero count, separate correct ignoring and immediate completion from a controller that restarts or hangs.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int BANK_W = 4;
  localparam int NBANK  = 1 << BANK_W;
endpackage

// File: rtl/ilv_seq.sv
module ilv_seq #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              ready_i,
  input  logic              drain_done_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  idx_o,
  output logic              last_o,
  output logic              we_o,
  output logic              zero_start_o
);
  logic              busy_q, iss_q, we_q;
  logic [ADDR_W-1:0] addr_q, stride_q;
  logic [CNT_W-1:0]  idx_q, left_q;
  logic              accept, fire;

  assign accept = start_i & ~busy_q;
  assign fire   = iss_q & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      iss_q    <= 1'b0;
      we_q     <= 1'b0;
      addr_q   <= '0;
      stride_q <= '0;
      idx_q    <= '0;
      left_q   <= '0;
    end else if (accept) begin
      busy_q   <= (count_i != '0);
      iss_q    <= (count_i != '0);
      we_q     <= we_i;
      addr_q   <= base_i;
      stride_q <= stride_i;
      idx_q    <= '0;
      left_q   <= count_i;
    end else begin
      if (fire) begin
        addr_q <= addr_q + stride_q;
        idx_q  <= idx_q + CNT_W'(1);
        left_q <= left_q - CNT_W'(1);
        if (left_q == CNT_W'(1)) iss_q <= 1'b0;
      end
      if (drain_done_i) busy_q <= 1'b0;
    end
  end

  assign valid_o      = iss_q;
  assign addr_o       = addr_q;
  assign idx_o        = idx_q;
  assign last_o       = (left_q == CNT_W'(1));
  assign we_o         = we_q;
  assign zero_start_o = accept & (count_i == '0);

  // R4
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_q && !ready_i) |=> ($stable(addr_q) && $stable(idx_q)));

  // R11
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !fire) |=> ($stable(addr_q) && $stable(idx_q) && $stable(stride_q)));

  // R1
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !start_i) |=> (addr_q == $past(addr_q) + stride_q));
endmodule

// File: rtl/ilv_bank_timers.sv
module ilv_bank_timers #(
  parameter int NB       = 16,
  parameter int BUSY_CYC = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] grant_i,
  output logic [NB-1:0] free_o
);
  localparam int TW = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (grant_i[b])        cnt_q <= TW'(BUSY_CYC - 1);
      else if (cnt_q != '0)       cnt_q <= cnt_q - TW'(1);
    end

    assign free_o[b] = (cnt_q == '0);

    // R2
    no_busy_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_i[b] |-> (cnt_q == '0));

    if (BUSY_CYC > 1) begin : g_hold
      // R2
      busy_after_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_i[b] |=> !free_o[b]);
    end
  end
endmodule

// File: rtl/ilv_bank_array.sv
module ilv_bank_array #(
  parameter int NB     = 16,
  parameter int BANK_W = 4,
  parameter int ROW_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int ROWS = 1 << ROW_W;

  logic [DATA_W-1:0] bank_rd [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DATA_W-1:0] cells [ROWS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < ROWS; r++) cells[r] <= '0;
      end else if (wr_i && (bank_i == BANK_W'(b))) begin
        cells[row_i] <= wdata_i;
      end
    end

    assign bank_rd[b] = cells[row_i];
  end

  assign rdata_o = bank_rd[bank_i];
endmodule

// File: rtl/ilv_ret_pipe.sv
module ilv_ret_pipe #(
  parameter int LAT    = 4,
  parameter int CNT_W  = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_v_i,
  input  logic              push_last_i,
  input  logic [CNT_W-1:0]  push_idx_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic              rd_valid_o,
  output logic [CNT_W-1:0]  rd_idx_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              last_o
);
  logic [LAT-1:0]    v_q, l_q;
  logic [CNT_W-1:0]  i_q [LAT];
  logic [DATA_W-1:0] d_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      l_q <= '0;
      for (int k = 0; k < LAT; k++) begin
        i_q[k] <= '0;
        d_q[k] <= '0;
      end
    end else begin
      v_q[0] <= push_v_i;
      l_q[0] <= push_last_i;
      i_q[0] <= push_idx_i;
      d_q[0] <= push_data_i;
      for (int k = 1; k < LAT; k++) begin
        v_q[k] <= v_q[k-1];
        l_q[k] <= l_q[k-1];
        i_q[k] <= i_q[k-1];
        d_q[k] <= d_q[k-1];
      end
    end
  end

  assign rd_valid_o = v_q[LAT-1];
  assign rd_idx_o   = i_q[LAT-1];
  assign rd_data_o  = d_q[LAT-1];
  assign last_o     = l_q[LAT-1];

  // R8
  in_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(rd_valid_o)) |-> (rd_idx_o == $past(rd_idx_o) + CNT_W'(1)));
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 7,
  parameter int BUSY_CYC = 4,
  parameter int RD_LAT   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              req_valid_o,
  output logic              req_ready_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [CNT_W-1:0]  req_idx_o,
  output logic              rd_valid_o,
  output logic [CNT_W-1:0]  rd_idx_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              done_o
);
  import ilv_pkg::*;

  localparam int ROW_W = ADDR_W - BANK_W;

  logic                 seq_valid, seq_last, seq_we, zero_start, drain_done;
  logic [ADDR_W-1:0]    seq_addr;
  logic [CNT_W-1:0]     seq_idx;
  logic [BANK_W-1:0]    bank;
  logic [ROW_W-1:0]     row;
  logic [NBANK-1:0]     bank_free, grant;
  logic                 fire;
  logic [DATA_W-1:0]    mem_rdata;
  logic                 done_q;

  assign bank = seq_addr[BANK_W-1:0];
  assign row  = seq_addr[ADDR_W-1:BANK_W];
  assign fire = seq_valid & bank_free[bank];

  always_comb begin
    grant       = '0;
    grant[bank] = fire;
  end

  ilv_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .we_i         (we_i),
    .base_i       (base_addr_i),
    .stride_i     (stride_i),
    .count_i      (count_i),
    .ready_i      (bank_free[bank]),
    .drain_done_i (drain_done),
    .valid_o      (seq_valid),
    .addr_o       (seq_addr),
    .idx_o        (seq_idx),
    .last_o       (seq_last),
    .we_o         (seq_we),
    .zero_start_o (zero_start)
  );

  ilv_bank_timers #(.NB(NBANK), .BUSY_CYC(BUSY_CYC)) u_timers (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .grant_i (grant),
    .free_o  (bank_free)
  );

  ilv_bank_array #(.NB(NBANK), .BANK_W(BANK_W), .ROW_W(ROW_W), .DATA_W(DATA_W)) u_banks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (fire & seq_we),
    .bank_i  (bank),
    .row_i   (row),
    .wdata_i (wdata_i),
    .rdata_o (mem_rdata)
  );

  ilv_ret_pipe #(.LAT(RD_LAT), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_ret (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_v_i    (fire & ~seq_we),
    .push_last_i (fire & seq_last),
    .push_idx_i  (seq_idx),
    .push_data_i (mem_rdata),
    .rd_valid_o  (rd_valid_o),
    .rd_idx_o    (rd_idx_o),
    .rd_data_o   (rd_data_o),
    .last_o      (drain_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= drain_done | zero_start;
  end

  assign req_valid_o = seq_valid;
  assign req_ready_o = seq_valid & bank_free[bank];
  assign req_addr_o  = seq_addr;
  assign req_idx_o   = seq_idx;
  assign done_o      = done_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rd_valid_o && !req_valid_o));

  // R9
  wr_no_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_valid && seq_we) |-> !rd_valid_o);
endmodule

// File: tb/ilv_mem_ctrl_tb.sv
module ilv_mem_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, we_i = 1'b0;
  logic [7:0]  base_addr_i = '0, stride_i = '0;
  logic [6:0]  count_i = '0;
  logic [15:0] wdata_i;
  logic        req_valid_o, req_ready_o, rd_valid_o, done_o;
  logic [7:0]  req_addr_o;
  logic [6:0]  req_idx_o, rd_idx_o;
  logic [15:0] rd_data_o;
  logic [7:0]  wseed = 8'h00;

  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  assign wdata_i = {wseed, 1'b0, req_idx_o};

  ilv_mem_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .we_i(we_i),
    .base_addr_i(base_addr_i), .stride_i(stride_i), .count_i(count_i),
    .wdata_i(wdata_i), .req_valid_o(req_valid_o), .req_ready_o(req_ready_o),
    .req_addr_o(req_addr_o), .req_idx_o(req_idx_o), .rd_valid_o(rd_valid_o),
    .rd_idx_o(rd_idx_o), .rd_data_o(rd_data_o), .done_o(done_o)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  // reference model state
  typedef struct { int due; int idx; logic [15:0] data; } ret_t;
  ret_t        rq[$];
  logic [15:0] ref_mem [256];
  int          free_at [16];
  int          cyc = 0, busy_until = 0, done_due = -1;
  bit          m_iss = 0, m_we = 0;
  int          m_addr = 0, m_stride = 0, m_idx = 0, m_left = 0;

  task automatic step();
    int  b;
    bit  rdy, rv;
    ret_t e;
    b   = m_addr & 15;
    rdy = m_iss && (cyc >= free_at[b]);
    chk("R3 req_valid", req_valid_o, m_iss);
    if (m_iss) begin
      chk("R1 req_addr", req_addr_o, 32'(m_addr));
      chk("R4 req_idx", req_idx_o, 32'(m_idx));
      chk("R2 req_ready", req_ready_o, rdy);
    end
    rv = (rq.size() > 0) && (rq[0].due == cyc);
    chk("R8 rd_valid", rd_valid_o, rv);
    if (rv) begin
      e = rq.pop_front();
      chk("R8 rd_idx", rd_idx_o, 32'(e.idx));
      chk("R9 rd_data", rd_data_o, 32'(e.data));
    end
    chk("R10 done", done_o, cyc == done_due);
    if (rdy) begin
      free_at[b] = cyc + 4;
      if (m_we) ref_mem[m_addr] = {wseed, 1'b0, 7'(m_idx)};
      else begin
        e.due = cyc + 4; e.idx = m_idx; e.data = ref_mem[m_addr];
        rq.push_back(e);
      end
      if (m_left == 1) begin
        m_iss = 0; done_due = cyc + 5; busy_until = cyc + 5;
      end
      m_addr = (m_addr + m_stride) & 255;
      m_idx++; m_left--;
    end
    if (start_i && !m_iss && cyc >= busy_until) begin
      if (count_i == 0) begin
        done_due = cyc + 1; busy_until = cyc + 1;
      end else begin
        m_iss = 1; m_we = we_i; m_addr = int'(base_addr_i);
        m_stride = int'($signed(stride_i)); m_idx = 0;
        m_left = int'(count_i); busy_until = 32'h7fffffff;
      end
    end
    cyc++;
  endtask

  always begin
    @(negedge clk);
    #2;
    if (rst_ni) step();
  end

  task automatic run(input logic w, input int base, input int stride, input int cnt,
                     input logic [7:0] seed, input int poke, output int n);
    @(negedge clk);
    wseed = seed; we_i = w; base_addr_i = 8'(base); stride_i = 8'(stride);
    count_i = 7'(cnt); start_i = 1'b1;
    n = -1;
    for (int k = 1; k <= 2000; k++) begin
      @(negedge clk);
      start_i = (k == poke);
      if (k == poke) begin
        base_addr_i = 8'(base + 77); stride_i = 8'd5; count_i = 7'd3; we_i = ~w;
      end
      #3;
      if (done_o) begin n = k; break; end
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog expired act=running exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < 256; i++) ref_mem[i] = '0;
    for (int i = 0; i < 16; i++) free_at[i] = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 req_valid", req_valid_o, 0);
    chk("R12 rd_valid", rd_valid_o, 0);
    chk("R12 done", done_o, 0);
    rst_ni = 1'b1;
    // R12 unwritten memory reads zero
    run(0, 200, 1, 4, 8'h00, 0, n);
    // R5 stride 1 write sweep, 64 elements back to back
    run(1, 0, 1, 64, 8'h11, 0, n);
    chk("R5 stride1 write cycles", n, 69);
    run(1, 64, 1, 64, 8'h22, 0, n);
    run(1, 128, 1, 64, 8'h33, 0, n);
    run(1, 192, 1, 64, 8'h44, 0, n);
    // R5 read strides without stall
    run(0, 0, 1, 16, 8'h00, 0, n);
    chk("R5 stride1 read cycles", n, 21);
    run(0, 3, 3, 40, 8'h00, 0, n);
    run(0, 1, 2, 30, 8'h00, 0, n);
    run(0, 0, 4, 8, 8'h00, 0, n);
    chk("R5 stride4 cycles", n, 13);
    // R6 conflicting strides
    run(0, 0, 8, 4, 8'h00, 0, n);
    chk("R6 stride8 cycles", n, 11);
    run(0, 5, 16, 4, 8'h00, 0, n);
    chk("R6 stride16 cycles", n, 18);
    run(0, 7, 24, 10, 8'h00, 0, n);
    // R7 negative strides with wrap
    run(0, 10, -1, 20, 8'h00, 0, n);
    chk("R7 stride-1 cycles", n, 25);
    run(0, 3, -8, 12, 8'h00, 0, n);
    run(1, 250, -16, 9, 8'h55, 0, n);
    run(0, 250, -16, 9, 8'h00, 0, n);
    // R9 strided write then read back at another stride
    run(1, 9, 16, 16, 8'h66, 0, n);
    run(0, 9, 16, 16, 8'h00, 0, n);
    run(0, 0, 1, 64, 8'h00, 0, n);
    // R11 start mid-transfer ignored
    run(0, 20, 8, 12, 8'h00, 5, n);
    run(1, 40, 3, 10, 8'h77, 4, n);
    run(0, 40, 3, 10, 8'h00, 0, n);
    // R10 zero count completes next cycle
    run(0, 0, 1, 0, 8'h00, 0, n);
    chk("R10 zero count cycles", n, 1);
    run(0, 100, 5, 3, 8'h00, 0, n);
    chk("R11 restart after done", n, 8);
    repeat (8) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule